// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port

This block is a parallel I/O port of configurable width, eight bits by default, controlled through a small synchronous register bus. Each bit is set as an input or an output on its own. A direction register chooses the bit's role. An output latch holds the value that output bits drive. A pin-read address returns the pin levels after they pass through a synchronizer. The pad is modelled as a per-bit output enable and output value, which a tristate buffer at the chip edge combines.

Writes to the pin-read address and to the latch address both land in the same output latch. Reads of the latch address return the stored latch value, and reads of the pin-read address return the sampled pin level. A read-modify-write sequence through the latch address therefore works on stored data, not on whatever the pins happen to show.

An external mode input hands the pads to a parallel slave port. In that mode the enables and values on the pads come from that port's own inputs, while the latch and direction registers keep their contents.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit reads 1 (input), `pin_oe` is all zero, and the latch reads 0.
- R2: A write strobe at offset 1 (latch) loads `wdata` into the output latch, and a read at offset 1 returns that value from the next cycle on.
- R3: A write strobe at offset 0 (port) also loads `wdata` into the output latch.
- R4: A write strobe at offset 2 (direction) loads the direction register, and a read at offset 2 returns its stored value.
- R5: Outside slave-port mode, a bit with direction 0 has `pin_oe` 1 and drives the latch bit on `pin_out`. A bit with direction 1 has `pin_oe` 0.
- R6: A read at offset 0 returns `pin_in` delayed through a two-stage synchronizer. A change on `pin_in` made between clock edges becomes visible after the second following rising edge and not after the first.
- R7: A read at offset 1 returns the stored latch value even when the pin levels differ from it.
- R8: While `psp_mode` is 1, `pin_oe` equals `psp_oe` and `pin_out` equals `psp_out`. The latch and direction keep their values, and port behaviour returns when `psp_mode` drops.
- R9: Offset 3 reads as zero, and a write strobe at offset 3 changes neither the latch nor the direction register.
- R10: With `wr_en` low, the latch and direction registers hold their values whatever `addr` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register offset: 0 port, 1 latch, 2 direction |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data for `addr` |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| pin_oe | output | WIDTH | Pad output enables, 1 = drive |
| pin_out | output | WIDTH | Pad output values |
| psp_mode | input | 1 | 1 hands the pads to the parallel slave port |
| psp_oe | input | WIDTH | Slave-port output enables |
| psp_out | input | WIDTH | Slave-port output values |

## Verification
The bench builds the block with WIDTH 8 and SYNC_STAGES 2. At these values every bit of a mixed direction pattern can be driven and observed in a single write, and the exact two-edge pin latency can be sampled after one edge and after two. Latch-versus-pin reads are checked with pin patterns that differ from the latch, and the slave-port handover is checked against registers that hold non-reset values.

// File: rtl/gpio_pkg.sv
// Package: shared register offsets for the GPIO port.
// Assumes a 2-bit register bus offset.
package gpio_pkg;
    localparam int ADDR_W = 2;
    typedef enum logic [ADDR_W-1:0] {
        OFS_PORT = 2'd0,
        OFS_LAT  = 2'd1,
        OFS_DIR  = 2'd2,
        OFS_NONE = 2'd3
    } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pad inputs.
// Assumes STAGES >= 1; flops clear to 0 on synchronous reset.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-times the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

    // R6: first stage follows the pad one edge later
    a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(d));
endmodule

// File: rtl/gpio_regs.sv
// Module: output latch and direction register with write decode.
// Assumes a one-cycle write strobe; direction resets to all inputs.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  dir_q
);
    logic lat_hit;
    logic dir_hit;

    // Decode: both port and latch offsets target the latch.
    always_comb begin
        lat_hit = wr_en && (addr == OFS_PORT || addr == OFS_LAT);
        dir_hit = wr_en && (addr == OFS_DIR);
    end

    // Output latch: clears on reset, loads on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (lat_hit) lat_q <= wdata;
    end

    // Direction register: all ones (inputs) on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= '1;
        else if (dir_hit) dir_q <= wdata;
    end

    // R2 and R3: write at port or latch offset lands in the latch
    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == OFS_PORT || addr == OFS_LAT) |=> lat_q == $past(wdata));
    // R4: write at direction offset lands in the direction register
    a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFS_DIR |=> dir_q == $past(wdata));
    // R10: no strobe, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(lat_q) && $stable(dir_q));
    // R9: unused offset leaves both registers alone
    a_r9_unused_ofs: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == OFS_NONE |=> $stable(lat_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_padmux.sv
// Module: selects pad drive between port registers and slave-port inputs.
// Assumes direction 1 = input; pin_out carries the latch in port mode.
module gpio_padmux #(
    parameter int WIDTH = 8
) (
    input  logic             psp_mode,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] psp_oe,
    input  logic [WIDTH-1:0] psp_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out
);
    // Pad drive source select.
    always_comb begin
        if (psp_mode) begin
            pin_oe  = psp_oe;
            pin_out = psp_out;
        end else begin
            pin_oe  = ~dir_q;
            pin_out = lat_q;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Module: top of the bidirectional GPIO port with register bus access.
// Assumes pin_in is asynchronous; rdata is combinational from addr.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    input  logic              psp_mode,
    input  logic [WIDTH-1:0]  psp_oe,
    input  logic [WIDTH-1:0]  psp_out
);
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .lat_q(lat_q), .dir_q(dir_q)
    );

    gpio_padmux #(.WIDTH(WIDTH)) u_padmux (
        .psp_mode(psp_mode), .lat_q(lat_q), .dir_q(dir_q),
        .psp_oe(psp_oe), .psp_out(psp_out),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Read multiplexer over the three register offsets.
    always_comb begin
        unique case (addr)
            OFS_PORT: rdata = pin_sync;
            OFS_LAT:  rdata = lat_q;
            OFS_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

    // R5: in port mode a driven pad shows the latch read back at offset 1
    a_r5_drive_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !psp_mode && addr == OFS_LAT |-> (pin_out & pin_oe) == (rdata & pin_oe));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_oe;
    logic [W-1:0] pin_out;
    logic         psp_mode = 1'b0;
    logic [W-1:0] psp_oe = '0;
    logic [W-1:0] psp_out = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_port #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .psp_mode(psp_mode), .psp_oe(psp_oe), .psp_out(psp_out)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(2'd2, v); check("R1 dir reset", v, 8'hFF);
        rd(2'd1, v); check("R1 latch reset", v, 8'h00);
        check("R1 oe reset", pin_oe, 8'h00);
    endtask

    task automatic t_latch_dir();
        logic [W-1:0] v;
        wr(2'd1, 8'hA5);
        rd(2'd1, v); check("R2 latch write", v, 8'hA5);
        wr(2'd0, 8'h3C);
        rd(2'd1, v); check("R3 port write to latch", v, 8'h3C);
        wr(2'd2, 8'hCF);
        rd(2'd2, v); check("R4 dir readback", v, 8'hCF);
        check("R5 oe from dir", pin_oe, 8'h30);
        check("R5 out from latch", pin_out & pin_oe, 8'h30 & 8'h3C);
        wr(2'd2, 8'h0F);
        check("R5 oe second pattern", pin_oe, 8'hF0);
    endtask

    task automatic t_sync();
        logic [W-1:0] v;
        @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk);
        rd(2'd0, v); check("R6 not after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R6 after two edges", v, 8'h5A);
        rd(2'd1, v); check("R7 latch not pins", v, 8'h3C);
        wr(2'd1, v | 8'h01);
        rd(2'd1, v); check("R7 rmw on latch", v, 8'h3D);
    endtask

    task automatic t_psp();
        logic [W-1:0] v;
        @(negedge clk);
        psp_oe = 8'h81; psp_out = 8'h80; psp_mode = 1'b1;
        #1;
        check("R8 psp oe", pin_oe, 8'h81);
        check("R8 psp out", pin_out, 8'h80);
        rd(2'd1, v); check("R8 latch kept", v, 8'h3D);
        rd(2'd2, v); check("R8 dir kept", v, 8'h0F);
        @(negedge clk);
        psp_mode = 1'b0;
        #1;
        check("R8 port restored", pin_oe, 8'hF0);
    endtask

    task automatic t_unused();
        logic [W-1:0] v;
        wr(2'd3, 8'h77);
        rd(2'd3, v); check("R9 offset 3 reads zero", v, 8'h00);
        rd(2'd1, v); check("R9 latch untouched", v, 8'h3D);
        rd(2'd2, v); check("R9 dir untouched", v, 8'h0F);
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd1; wdata = 8'hEE;
        @(negedge clk); addr = 2'd2;
        @(negedge clk);
        rd(2'd1, v); check("R10 latch holds", v, 8'h3D);
        rd(2'd2, v); check("R10 dir holds", v, 8'h0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_dir();
        t_sync();
        t_psp();
        t_unused();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule